// File: doc/BRIEF.md
# Streaming Header Parser and Source-Address Drop Filter

The block takes Ethernet frames one byte per cycle, marked with start-of-frame and end-of-frame flags, and walks a fixed parse graph over them: the Ethernet header is always taken first. A type value of 0x0800 leads to the IPv4 header, and a protocol byte of 6 there leads to the TCP header. Every other branch accepts the frame at once. Frames that reach IPv4 have their 32-bit source address looked up in an exact-match table. A hit discards the whole frame. A miss takes the fixed do-nothing default, so the frame leaves unchanged.

Frame bytes wait in an internal buffer until the verdict for their frame exists, so a discarded frame never shows a single output beat. The table is a hashed set-associative store that a request/acknowledge control port fills and empties while traffic flows. The same port reads three frame counters. Input framing is assumed well formed: every start flag is eventually followed by an end flag, and the input has no backpressure.

Parser states: `PS_IDLE` (between frames), `PS_ETH` (bytes 0..13), `PS_IPV4` (bytes 14..33), `PS_TCP` (bytes 34..53), `PS_TAIL` (verdict issued, waiting for the end flag). Parser transitions:
- IDLE→ETH on a start flag.
- ETH→IPV4 on type 0x0800 at byte 13.
- ETH→TAIL on any other type at byte 13.
- IPV4→TCP on protocol 6 at byte 33.
- IPV4→TAIL on any other protocol at byte 33.
- TCP→TAIL at byte 53.
- Any state→IDLE on an end flag.

Egress states: `EG_IDLE` (waiting for a head frame with a verdict), `EG_PASS` (emitting), `EG_DISCARD` (flushing). Egress transitions:
- IDLE→PASS or IDLE→DISCARD when a verdict is taken.
- PASS→IDLE or DISCARD→IDLE on the end byte.

Top module: `hdr_src_filter`

## Requirements
- R1: Bytes 12 (high) and 13 (low) form the type field. When it is not 0x0800, the frame is forwarded unchanged without any table lookup, even when bytes 26..29 hold a stored key.
- R2: With type 0x0800, the protocol is byte 23. A value other than 6 gives a verdict once byte 33 (the end of a 20-byte IPv4 header) arrives, using a lookup.
- R3: With protocol 6, the verdict comes once byte 53 (the end of a 20-byte TCP header) arrives, using a lookup.
- R4: The lookup key is bytes 26..29, with byte 26 as the most significant. A hit discards the whole frame, and the frame produces no output beat.
- R5: A miss forwards every byte in order. The start flag is on the first output beat and the end flag on the last. Neither flag appears without a valid beat.
- R6: A frame whose end flag arrives before its verdict point (byte 13, 33 or 53 for its path) is forwarded without a lookup.
- R7: Control op 0 adds a key to set index = XOR of its four bytes. The acknowledge comes one cycle after the request. Adding a key already present is acknowledged without error. Adding a key to a set whose 4 ways are full sets the error flag and stores nothing.
- R8: Control op 1 deletes a key, after which matching frames are forwarded. Deleting an absent key sets the error flag.
- R9: Control op 2 returns a counter in the acknowledge cycle. Select bits [1:0] of the key pick which one: 0 gives frames received, 1 gives frames discarded on a hit, 2 gives frames forwarded.
- R10: After reset, no output beat is present, the table is empty, and all counters read zero.
- R11: Frames may arrive back to back with no idle cycle, and every verdict still applies to its own frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | Input byte is first of frame |
| in_eof | input | 1 | Input byte is last of frame |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte present |
| out_sof | output | 1 | Output byte is first of frame |
| out_eof | output | 1 | Output byte is last of frame |
| out_data | output | 8 | Output byte |
| ctl_req | input | 1 | Control request strobe |
| ctl_op | input | 2 | 0 add, 1 delete, 2 read counter |
| ctl_key | input | 32 | Key for add or delete; counter select in bits [1:0] |
| ctl_ack | output | 1 | Control acknowledge, one cycle after the request |
| ctl_err | output | 1 | Control operation refused |
| ctl_rdata | output | 32 | Counter value on a read acknowledge |

## Verification
The control results (acknowledge, error flag and counter value) are registered, so they are due on the edge right after the request. The bench drives requests on a falling edge and samples at the next falling edge. A forwarded frame's first beat is due one edge after its verdict byte is captured, and later beats follow one per cycle. Because of this, a monitor records every output beat at falling edges, and each frame is compared only after a quiet window well beyond the longest frame plus that latency. A discarded frame is checked by the absence of any recorded beat in its window, not at one cycle.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    localparam logic [15:0] TYPE_IPV4     = 16'h0800;
    localparam logic [7:0]  PROTO_TCP     = 8'd6;
    localparam int unsigned OFF_TYPE_HI   = 12;
    localparam int unsigned OFF_ETH_END   = 13;
    localparam int unsigned OFF_PROTO     = 23;
    localparam int unsigned OFF_SRC       = 26;
    localparam int unsigned OFF_IPV4_END  = 33;
    localparam int unsigned OFF_TCP_END   = 53;

    typedef enum logic [2:0] {
        PS_IDLE, PS_ETH, PS_IPV4, PS_TCP, PS_TAIL
    } parse_state_t;

    typedef enum logic [1:0] {
        EG_IDLE, EG_PASS, EG_DISCARD
    } egress_state_t;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_DEL  = 2'd1,
        OP_READ = 2'd2
    } ctl_op_t;

    typedef struct packed {
        logic [7:0]  type_hi;
        logic [7:0]  proto;
        logic [31:0] src;
    } hdr_rec_t;

endpackage

// File: rtl/sfp_sync_fifo.sv
module sfp_sync_fifo #(
    parameter int unsigned WIDTH = 10,
    parameter int unsigned DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int unsigned AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [AW:0]      level;

    assign dout  = mem[rd_ptr];
    assign empty = (level == '0);
    assign full  = (level == (AW+1)'(DEPTH));

    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push && !full)  wr_ptr <= wr_ptr + 1'b1;
            if (pop && !empty)  rd_ptr <= rd_ptr + 1'b1;
            level <= level + (AW+1)'(push && !full) - (AW+1)'(pop && !empty);
        end
    end
endmodule

// File: rtl/sfp_parser.sv
module sfp_parser
    import sfp_pkg::*;
#(
    parameter int unsigned IDX_W = $clog2(OFF_TCP_END + 2)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic [7:0]  in_data,
    output logic        take,
    output logic        decide,
    output logic        lookup,
    output logic [31:0] src_key
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    parse_state_t     state, nxt, cur;
    hdr_rec_t         hdr;
    logic [IDX_W-1:0] cnt, idx;

    assign src_key = hdr.src;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        take   = in_valid && (in_sof || state != PS_IDLE);
        idx    = in_sof ? '0 : cnt;
        cur    = in_sof ? PS_ETH : state;
        nxt    = state;
        decide = 1'b0;
        lookup = 1'b0;
        if (take) begin
            nxt = cur;
            unique case (cur)
                PS_ETH: begin
                    if (idx == IDX_W'(OFF_ETH_END)) begin
                        if ({hdr.type_hi, in_data} == TYPE_IPV4) begin
                            nxt = PS_IPV4;
                        end else begin
                            decide = 1'b1;
                            nxt    = PS_TAIL;
                        end
                    end
                end
                PS_IPV4: begin
                    if (idx == IDX_W'(OFF_IPV4_END)) begin
                        if (hdr.proto == PROTO_TCP) begin
                            nxt = PS_TCP;
                        end else begin
                            decide = 1'b1;
                            lookup = 1'b1;
                            nxt    = PS_TAIL;
                        end
                    end
                end
                PS_TCP: begin
                    if (idx == IDX_W'(OFF_TCP_END)) begin
                        decide = 1'b1;
                        lookup = 1'b1;
                        nxt    = PS_TAIL;
                    end
                end
                PS_TAIL, PS_IDLE: ;
            endcase
            if (in_eof) begin
                if (!decide && cur != PS_TAIL) decide = 1'b1;
                nxt = PS_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            hdr <= '0;
        end else if (take) begin
            cnt <= (idx == IDX_MAX) ? idx : idx + 1'b1;
            if (idx == IDX_W'(OFF_TYPE_HI)) hdr.type_hi <= in_data;
            if (idx == IDX_W'(OFF_PROTO))   hdr.proto   <= in_data;
            if (idx >= IDX_W'(OFF_SRC) && idx < IDX_W'(OFF_SRC + 4))
                hdr.src <= {hdr.src[23:0], in_data};
        end
    end
endmodule

// File: rtl/sfp_match_table.sv
module sfp_match_table #(
    parameter int unsigned KEY_W    = 32,
    parameter int unsigned SET_BITS = 8,
    parameter int unsigned WAYS     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] lk_key,
    output logic             lk_hit,
    input  logic             wr_en,
    input  logic             wr_del,
    input  logic [KEY_W-1:0] wr_key,
    output logic             wr_ok
);
    localparam int unsigned SETS  = 1 << SET_BITS;
    localparam int unsigned FOLDS = (KEY_W + SET_BITS - 1) / SET_BITS;
    localparam int unsigned WW    = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [KEY_W-1:0] keys [SETS][WAYS];
    logic [WAYS-1:0]  vld  [SETS];

    function automatic logic [SET_BITS-1:0] fold(input logic [KEY_W-1:0] k);
        logic [SET_BITS-1:0] h;
        h = '0;
        for (int i = 0; i < FOLDS; i++) h ^= SET_BITS'(k >> (i * SET_BITS));
        return h;
    endfunction

    logic [SET_BITS-1:0] lk_set, wr_set;
    logic [WAYS-1:0]     lk_match, wr_match;
    logic [WW-1:0]       free_way;
    logic                have_free, do_add, do_del;

    assign lk_set = fold(lk_key);
    assign wr_set = fold(wr_key);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign lk_match[w] = vld[lk_set][w] && (keys[lk_set][w] == lk_key);
        assign wr_match[w] = vld[wr_set][w] && (keys[wr_set][w] == wr_key);
    end

    assign lk_hit = |lk_match;

    always_comb begin
        have_free = 1'b0;
        free_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[wr_set][w]) begin
                have_free = 1'b1;
                free_way  = WW'(w);
            end
        end
    end

    assign wr_ok  = wr_del ? (|wr_match) : ((|wr_match) || have_free);
    assign do_add = wr_en && !wr_del && !(|wr_match) && have_free;
    assign do_del = wr_en && wr_del && (|wr_match);

    always_ff @(posedge clk) begin
        if (do_add) keys[wr_set][free_way] <= wr_key;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld[s] <= '0;
        end else if (do_add) begin
            vld[wr_set][free_way] <= 1'b1;
        end else if (do_del) begin
            vld[wr_set] <= vld[wr_set] & ~wr_match;
        end
    end
endmodule

// File: rtl/sfp_egress.sv
module sfp_egress
    import sfp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [9:0] head,
    input  logic       buf_empty,
    input  logic       verdict_drop,
    input  logic       verdict_empty,
    output logic       buf_pop,
    output logic       verdict_pop,
    output logic       out_valid,
    output logic       out_sof,
    output logic       out_eof,
    output logic [7:0] out_data
);
    egress_state_t state, nxt;
    logic          emit;
    logic          head_eof;

    assign head_eof = head[8];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= EG_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt         = state;
        buf_pop     = 1'b0;
        verdict_pop = 1'b0;
        emit        = 1'b0;
        unique case (state)
            EG_IDLE: begin
                if (!buf_empty && !verdict_empty) begin
                    buf_pop     = 1'b1;
                    verdict_pop = 1'b1;
                    emit        = !verdict_drop;
                    if (!head_eof) nxt = verdict_drop ? EG_DISCARD : EG_PASS;
                end
            end
            EG_PASS: begin
                if (!buf_empty) begin
                    buf_pop = 1'b1;
                    emit    = 1'b1;
                    if (head_eof) nxt = EG_IDLE;
                end
            end
            EG_DISCARD: begin
                if (!buf_empty) begin
                    buf_pop = 1'b1;
                    if (head_eof) nxt = EG_IDLE;
                end
            end
            default: nxt = EG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= emit;
            out_sof   <= emit && head[9];
            out_eof   <= emit && head_eof;
            out_data  <= head[7:0];
        end
    end
endmodule

// File: rtl/hdr_src_filter.sv
module hdr_src_filter
    import sfp_pkg::*;
#(
    parameter int unsigned SET_BITS  = 8,
    parameter int unsigned WAYS      = 4,
    parameter int unsigned BUF_DEPTH = 64,
    parameter int unsigned CTR_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    output logic             out_valid,
    output logic             out_sof,
    output logic             out_eof,
    output logic [7:0]       out_data,
    input  logic             ctl_req,
    input  logic [1:0]       ctl_op,
    input  logic [31:0]      ctl_key,
    output logic             ctl_ack,
    output logic             ctl_err,
    output logic [CTR_W-1:0] ctl_rdata
);
    localparam int unsigned BEAT_W = 10;

    logic        take, decide, lookup, hit, drop;
    logic [31:0] src_key;
    logic [BEAT_W-1:0] head;
    logic        buf_empty, buf_full, buf_pop;
    logic        dq_drop, dq_empty, dq_full, dq_pop;
    logic        wr_en, wr_ok;
    logic [CTR_W-1:0] rx_cnt, drop_cnt, fwd_cnt;

    sfp_parser u_parser (
        .clk, .rst_n, .in_valid, .in_sof, .in_eof, .in_data,
        .take, .decide, .lookup, .src_key
    );

    assign wr_en = ctl_req && (ctl_op == OP_ADD || ctl_op == OP_DEL);

    sfp_match_table #(.KEY_W(32), .SET_BITS(SET_BITS), .WAYS(WAYS)) u_table (
        .clk, .rst_n,
        .lk_key (src_key),
        .lk_hit (hit),
        .wr_en  (wr_en),
        .wr_del (ctl_op == OP_DEL),
        .wr_key (ctl_key),
        .wr_ok  (wr_ok)
    );

    assign drop = lookup && hit;

    sfp_sync_fifo #(.WIDTH(BEAT_W), .DEPTH(BUF_DEPTH)) u_beats (
        .clk, .rst_n,
        .push  (take),
        .din   ({in_sof, in_eof, in_data}),
        .pop   (buf_pop),
        .dout  (head),
        .empty (buf_empty),
        .full  (buf_full)
    );

    sfp_sync_fifo #(.WIDTH(1), .DEPTH(BUF_DEPTH)) u_verdicts (
        .clk, .rst_n,
        .push  (decide),
        .din   (drop),
        .pop   (dq_pop),
        .dout  (dq_drop),
        .empty (dq_empty),
        .full  (dq_full)
    );

    sfp_egress u_egress (
        .clk, .rst_n,
        .head, .buf_empty,
        .verdict_drop  (dq_drop),
        .verdict_empty (dq_empty),
        .buf_pop, .verdict_pop (dq_pop),
        .out_valid, .out_sof, .out_eof, .out_data
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_cnt   <= '0;
            drop_cnt <= '0;
            fwd_cnt  <= '0;
        end else begin
            if (take && in_sof)     rx_cnt   <= rx_cnt + 1'b1;
            if (decide && drop)     drop_cnt <= drop_cnt + 1'b1;
            if (decide && !drop)    fwd_cnt  <= fwd_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_ack   <= 1'b0;
            ctl_err   <= 1'b0;
            ctl_rdata <= '0;
        end else begin
            ctl_ack   <= ctl_req;
            ctl_err   <= 1'b0;
            ctl_rdata <= '0;
            if (ctl_req) begin
                unique case (ctl_op)
                    OP_ADD, OP_DEL: ctl_err <= !wr_ok;
                    OP_READ: begin
                        unique case (ctl_key[1:0])
                            2'd0:    ctl_rdata <= rx_cnt;
                            2'd1:    ctl_rdata <= drop_cnt;
                            2'd2:    ctl_rdata <= fwd_cnt;
                            default: ctl_err   <= 1'b1;
                        endcase
                    end
                    default: ctl_err <= 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/sfp_filter_checker.sv
module sfp_filter_checker (
    input logic clk,
    input logic rst_n,
    input logic out_valid,
    input logic out_sof,
    input logic out_eof,
    input logic ctl_req,
    input logic ctl_ack,
    input logic ctl_err,
    input logic beat_push,
    input logic beat_full,
    input logic verdict_push,
    input logic verdict_full
);
    logic in_frame;

    always_ff @(posedge clk) begin
        if (!rst_n)         in_frame <= 1'b0;
        else if (out_valid) in_frame <= !out_eof;
    end

    // R7: every request is acknowledged on the next edge
    assert_ack_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_req |=> ctl_ack);

    // R8: the error flag only accompanies an acknowledge
    assert_err_with_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_err |-> ctl_ack);

    // R5: frame marks never appear on an idle output
    assert_marks_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof || out_eof) |-> out_valid);

    // R5: a start beat only outside a frame, a continuation only inside one
    assert_start_outside_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sof) |-> !in_frame);
    assert_cont_inside_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sof) |-> in_frame);

    // R11: back-to-back traffic never overruns the internal buffers
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        beat_push |-> !beat_full);
    assert_no_verdict_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_push |-> !verdict_full);
endmodule

bind hdr_src_filter sfp_filter_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .out_valid    (out_valid),
    .out_sof      (out_sof),
    .out_eof      (out_eof),
    .ctl_req      (ctl_req),
    .ctl_ack      (ctl_ack),
    .ctl_err      (ctl_err),
    .beat_push    (take),
    .beat_full    (buf_full),
    .verdict_push (decide),
    .verdict_full (dq_full)
);

// File: tb/hdr_src_filter_bench.sv
`timescale 1ns/1ps
module hdr_src_filter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_valid, out_sof, out_eof;
    logic [7:0]  out_data;
    logic        ctl_req = 1'b0;
    logic [1:0]  ctl_op = '0;
    logic [31:0] ctl_key = '0;
    logic        ctl_ack, ctl_err;
    logic [31:0] ctl_rdata;

    int checks = 0;
    int errors = 0;
    int n_rx = 0, n_drop = 0, n_fwd = 0;

    always #2 clk = ~clk;

    hdr_src_filter u_hdr_src_filter (
        .clk, .rst_n, .in_valid, .in_sof, .in_eof, .in_data,
        .out_valid, .out_sof, .out_eof, .out_data,
        .ctl_req, .ctl_op, .ctl_key, .ctl_ack, .ctl_err, .ctl_rdata
    );

    // kind: 0 non-IP, 1 IPv4 non-TCP, 2 IPv4 TCP
    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] src;
        logic [15:0] len;
        logic        drop;
        logic [3:0]  req;
    } vec_t;

    localparam logic [31:0] KEY_A = 32'h0A00_0001;
    localparam logic [31:0] KEY_B = 32'hC0A8_0105;
    localparam logic [31:0] KEY_C = 32'h0A00_0002;
    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{2'd0, KEY_A, 16'd60, 1'b0, 4'd1},
        '{2'd1, KEY_A, 16'd64, 1'b1, 4'd2},
        '{2'd1, KEY_C, 16'd64, 1'b0, 4'd5},
        '{2'd2, KEY_B, 16'd70, 1'b1, 4'd3},
        '{2'd2, KEY_C, 16'd54, 1'b0, 4'd3},
        '{2'd2, KEY_A, 16'd40, 1'b0, 4'd6},
        '{2'd1, KEY_A, 16'd30, 1'b0, 4'd6},
        '{2'd0, KEY_B, 16'd10, 1'b0, 4'd6}
    };

    function automatic string rq(input logic [3:0] n);
        case (n)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd11: return "R11";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [7:0] fbyte(input logic [1:0] kind, input logic [31:0] src, input int i);
        case (i)
            12: return (kind == 2'd0) ? 8'h86 : 8'h08;
            13: return (kind == 2'd0) ? 8'hDD : 8'h00;
            23: return (kind == 2'd2) ? 8'd6 : 8'd17;
            26: return src[31:24];
            27: return src[23:16];
            28: return src[15:8];
            29: return src[7:0];
            default: return 8'((i * 13) + (kind * 5) + 1);
        endcase
    endfunction

    logic [9:0] cap [4096];
    int cap_n = 0;

    always @(negedge clk) begin
        if (rst_n && out_valid && cap_n < 4096) begin
            cap[cap_n] = {out_sof, out_eof, out_data};
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic send_frame(input logic [1:0] kind, input logic [31:0] src, input int len, input bit drop);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
            in_data  = fbyte(kind, src, i);
            @(negedge clk);
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        n_rx++;
        if (drop) n_drop++; else n_fwd++;
    endtask

    // compares the recorded beats from index pos against one frame; returns the next index
    task automatic expect_frame(inout int pos, input logic [1:0] kind, input logic [31:0] src,
                                input int len, input bit drop, input string tag);
        bit ok;
        int bad;
        ok = 1'b1;
        bad = 0;
        if (!drop) begin
            for (int i = 0; i < len; i++) begin
                if (pos + i >= cap_n ||
                    cap[pos + i] != {(i == 0), (i == len - 1), fbyte(kind, src, i)}) begin
                    if (ok) bad = i;
                    ok = 1'b0;
                end
            end
            check(ok, tag, "forwarded frame beat index", bad, -1);
            pos = pos + len;
        end
    endtask

    task automatic ctl(input logic [1:0] op, input logic [31:0] key);
        ctl_req = 1'b1; ctl_op = op; ctl_key = key;
        @(negedge clk);
        ctl_req = 1'b0;
    endtask

    task automatic ctl_expect(input logic [1:0] op, input logic [31:0] key, input bit exp_err, input string tag);
        ctl(op, key);
        check(ctl_ack === 1'b1, tag, "ack", ctl_ack, 1);
        check(ctl_err === exp_err, tag, "err", ctl_err, exp_err);
    endtask

    task automatic read_expect(input logic [1:0] sel, input int exp, input string tag);
        ctl(2'd2, {30'd0, sel});
        check(ctl_ack === 1'b1 && ctl_rdata == exp, tag, "counter", ctl_rdata, exp);
    endtask

    task automatic quiet();
        repeat (120) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int pos;
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check(out_valid === 1'b0, "R10", "out_valid after reset", out_valid, 0);
        read_expect(2'd0, 0, "R10");
        read_expect(2'd1, 0, "R10");
        read_expect(2'd2, 0, "R10");
        // R10: empty table, a matching IPv4 frame passes
        base = cap_n;
        send_frame(2'd1, KEY_A, 40, 1'b0);
        quiet();
        pos = base;
        expect_frame(pos, 2'd1, KEY_A, 40, 1'b0, "R10");

        // R7: add keys
        ctl_expect(2'd0, KEY_A, 1'b0, "R7");
        ctl_expect(2'd0, KEY_B, 1'b0, "R7");

        // vector table walk: R1 R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            base = cap_n;
            send_frame(VEC[v].kind, VEC[v].src, int'(VEC[v].len), VEC[v].drop);
            quiet();
            pos = base;
            expect_frame(pos, VEC[v].kind, VEC[v].src, int'(VEC[v].len), VEC[v].drop, rq(VEC[v].req));
            check(cap_n == pos, VEC[v].drop ? "R4" : rq(VEC[v].req), "beats emitted", cap_n - base, pos - base);
        end

        // R11: back to back, forward / discard / forward / forward
        base = cap_n;
        send_frame(2'd2, KEY_C, 54, 1'b0);
        send_frame(2'd1, KEY_B, 34, 1'b1);
        send_frame(2'd0, KEY_A, 14, 1'b0);
        send_frame(2'd1, KEY_C, 64, 1'b0);
        quiet();
        pos = base;
        expect_frame(pos, 2'd2, KEY_C, 54, 1'b0, "R11");
        expect_frame(pos, 2'd0, KEY_A, 14, 1'b0, "R11");
        expect_frame(pos, 2'd1, KEY_C, 64, 1'b0, "R11");
        check(cap_n == pos, "R11", "beats emitted", cap_n - base, pos - base);

        // R9: counters
        read_expect(2'd0, n_rx, "R9");
        read_expect(2'd1, n_drop, "R9");
        read_expect(2'd2, n_fwd, "R9");

        // R8: delete, then the key no longer matches
        ctl_expect(2'd1, KEY_A, 1'b0, "R8");
        base = cap_n;
        send_frame(2'd1, KEY_A, 64, 1'b0);
        quiet();
        pos = base;
        expect_frame(pos, 2'd1, KEY_A, 64, 1'b0, "R8");
        ctl_expect(2'd1, KEY_A, 1'b1, "R8");

        // R7: fill set 0 (XOR of key bytes is 0), fifth add refused, duplicate accepted
        for (int k = 1; k <= 4; k++) ctl_expect(2'd0, {8'(k), 8'(k), 16'h0000}, 1'b0, "R7");
        ctl_expect(2'd0, 32'h0505_0000, 1'b1, "R7");
        ctl_expect(2'd0, 32'h0101_0000, 1'b0, "R7");
        base = cap_n;
        send_frame(2'd1, 32'h0505_0000, 40, 1'b0);
        send_frame(2'd2, 32'h0404_0000, 60, 1'b1);
        quiet();
        pos = base;
        expect_frame(pos, 2'd1, 32'h0505_0000, 40, 1'b0, "R7");
        check(cap_n == pos, "R4", "beats emitted for stored key", cap_n - base, pos - base);
        read_expect(2'd1, n_drop, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule